// File: doc/BRIEF.md
# Half-Duplex Carrier Sense and Collision Generator

This block produces the carrier-sense and collision indications that a 10/100 Ethernet PHY presents to its MAC over the media-independent interface. It takes already-qualified transmit and receive activity flags, a duplex select, a speed select, a heartbeat enable and a single-cycle strobe that marks each bit time. From these it drives the `crs` and `col` outputs, which are both registered.

Carrier sense follows receive activity alone in full duplex. In half duplex it also covers transmit activity. A collision exists only in half duplex, while both directions are active. At 10 Mb/s, a collision that begins on top of an ongoing transmission is held back until the overlap has lasted seven bit strobes without a break. This filters out short noise overlaps. A collision that lands on a receive already in progress is reported at once, and so is any collision at 100 Mb/s. When heartbeat is enabled at 10 Mb/s in half duplex, a signal-quality pulse is placed on `col` after each transmitted frame ends. It follows a gap of ten bit strobes and lasts ten bit strobes. A new transmission cancels a pulse that is still pending.

Top module: `mii_crs_col_gen`

## Requirements
- R1: With `full_duplex` high at a clock edge, `col` is low after that edge, whatever the activity or heartbeat inputs are.
- R2: At 10 Mb/s (`speed_100`=0) in half duplex, if transmit was active before receive joined it (or both started in the same cycle), `col` rises one cycle after the edge that samples the 7th `bit_tick` of an unbroken overlap. If the overlap breaks before that, the count restarts from zero and `col` stays low.
- R3: A half-duplex overlap reports `col` on the cycle after it is first sampled in two cases: when `speed_100`=1, or when receive was active without transmit on some earlier edge and has stayed active since then.
- R4: `col` stays high for as long as the overlap persists. Once an edge samples no overlap, `col` is low after that edge unless a heartbeat pulse is active.
- R5: With `sqe_en`=1, `speed_100`=0 and half duplex, the edge that first samples `tx_active` low after it was high starts a gap of 10 `bit_tick`s. A pulse on `col` follows and lasts 10 `bit_tick`s. No pulse is produced at 100 Mb/s or with `sqe_en`=0.
- R6: In half duplex, `crs` equals (`tx_active` OR `rx_active`) as sampled at the previous edge.
- R7: In full duplex, `crs` equals `rx_active` as sampled at the previous edge. Transmit activity has no effect on it.
- R8: Synchronous active-high `rst` clears `crs`, `col` and all internal counters on the next edge.
- R9: Sampling `tx_active` high while a heartbeat gap or pulse is pending cancels it. `col` is then low unless an overlap drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_active | input | 1 | Transmit in progress |
| rx_active | input | 1 | Qualified receive activity |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| sqe_en | input | 1 | Heartbeat (signal-quality pulse) enable |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision indication |

## Verification
The bench builds the block with its default parameters: a 7-bit qualification window, and a heartbeat gap and pulse of 10 bits each. It drives `bit_tick` once every four clocks, so each window spans a few dozen cycles. This makes every duplex, speed and heartbeat combination reachable, together with three activity orderings (receive first, transmit first, simultaneous). Each ordering runs with both a short overlap (five bit times, below the window) and a long one. A transmit restart inside the heartbeat gap exercises cancellation, and a later long idle lets the full pulse play out.

// File: rtl/mii_cc_pkg.sv
package mii_cc_pkg;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_GAP   = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_t;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/cc_carrier_sense.sv
module cc_carrier_sense (
  input  logic clk,
  input  logic rst,
  input  logic tx_active,
  input  logic rx_active,
  input  logic full_duplex,
  output logic crs_q
);

  logic crs_d;

  always_comb begin
    if (full_duplex) crs_d = rx_active;
    else             crs_d = rx_active | tx_active;
  end

  always_ff @(posedge clk) begin
    if (rst) crs_q <= 1'b0;
    else     crs_q <= crs_d;
  end

endmodule

// File: rtl/cc_collision_qual.sv
module cc_collision_qual #(
  parameter int QUAL_BITS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_active,
  input  logic rx_active,
  input  logic full_duplex,
  input  logic speed_100,
  input  logic bit_tick,
  output logic coll_q
);

  localparam int CW = mii_cc_pkg::cnt_width(QUAL_BITS);
  localparam logic [CW-1:0] QUAL_LIM = CW'(QUAL_BITS);

  logic          overlap;
  logic          rx_lead_q;
  logic          immediate;
  logic [CW-1:0] qcnt_q;
  logic [CW-1:0] qcnt_d;

  assign overlap   = ~full_duplex & tx_active & rx_active;
  assign immediate = speed_100 | rx_lead_q;

  always_comb begin
    qcnt_d = qcnt_q;
    if (!overlap)                             qcnt_d = '0;
    else if (bit_tick && (qcnt_q < QUAL_LIM)) qcnt_d = qcnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qcnt_q    <= '0;
      rx_lead_q <= 1'b0;
      coll_q    <= 1'b0;
    end else begin
      qcnt_q    <= qcnt_d;
      rx_lead_q <= rx_active & (rx_lead_q | ~tx_active);
      coll_q    <= overlap & (immediate | (qcnt_d == QUAL_LIM));
    end
  end

endmodule

// File: rtl/cc_sqe_gen.sv
module cc_sqe_gen #(
  parameter int GAP_BITS = 10,
  parameter int LEN_BITS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_active,
  input  logic full_duplex,
  input  logic speed_100,
  input  logic sqe_en,
  input  logic bit_tick,
  output logic pulse_q
);
  import mii_cc_pkg::*;

  localparam int MAXB = (GAP_BITS > LEN_BITS) ? GAP_BITS : LEN_BITS;
  localparam int CW   = cnt_width(MAXB);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_BITS - 1);
  localparam logic [CW-1:0] LEN_LAST = CW'(LEN_BITS - 1);

  hb_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tx_prev_q;
  logic          launch;

  assign launch = tx_prev_q & ~tx_active & sqe_en & ~speed_100;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (full_duplex || tx_active) begin
      st_d  = HB_IDLE;
      cnt_d = '0;
    end else if (launch) begin
      st_d  = HB_GAP;
      cnt_d = '0;
    end else if (bit_tick) begin
      case (st_q)
        HB_GAP: begin
          if (cnt_q == GAP_LAST) begin
            st_d  = HB_PULSE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        HB_PULSE: begin
          if (cnt_q == LEN_LAST) begin
            st_d  = HB_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = HB_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= HB_IDLE;
      cnt_q     <= '0;
      tx_prev_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      tx_prev_q <= tx_active;
      pulse_q   <= (st_d == HB_PULSE);
    end
  end

endmodule

// File: rtl/mii_crs_col_gen.sv
module mii_crs_col_gen #(
  parameter int QUAL_BITS = 7,
  parameter int GAP_BITS  = 10,
  parameter int LEN_BITS  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_active,
  input  logic rx_active,
  input  logic full_duplex,
  input  logic speed_100,
  input  logic sqe_en,
  input  logic bit_tick,
  output logic crs,
  output logic col
);

  logic coll_q;
  logic sqe_on;

  cc_carrier_sense u_crs (
    .clk         (clk),
    .rst         (rst),
    .tx_active   (tx_active),
    .rx_active   (rx_active),
    .full_duplex (full_duplex),
    .crs_q       (crs)
  );

  cc_collision_qual #(.QUAL_BITS(QUAL_BITS)) u_qual (
    .clk         (clk),
    .rst         (rst),
    .tx_active   (tx_active),
    .rx_active   (rx_active),
    .full_duplex (full_duplex),
    .speed_100   (speed_100),
    .bit_tick    (bit_tick),
    .coll_q      (coll_q)
  );

  cc_sqe_gen #(.GAP_BITS(GAP_BITS), .LEN_BITS(LEN_BITS)) u_sqe (
    .clk         (clk),
    .rst         (rst),
    .tx_active   (tx_active),
    .full_duplex (full_duplex),
    .speed_100   (speed_100),
    .sqe_en      (sqe_en),
    .bit_tick    (bit_tick),
    .pulse_q     (sqe_on)
  );

  assign col = coll_q | sqe_on;

endmodule

// File: rtl/mii_crs_col_gen_chk.sv
module mii_crs_col_gen_chk (
  input logic clk,
  input logic rst,
  input logic tx_active,
  input logic rx_active,
  input logic full_duplex,
  input logic speed_100,
  input logic crs,
  input logic col,
  input logic sqe_on
);

  AST_FD_NO_COL: assert property (@(posedge clk) disable iff (rst)
    full_duplex |=> !col); // R1

  AST_IMM_100: assert property (@(posedge clk) disable iff (rst)
    (!full_duplex && tx_active && rx_active && speed_100) |=> col); // R3

  AST_COL_DROP: assert property (@(posedge clk) disable iff (rst)
    !(tx_active && rx_active) |=> (col == sqe_on)); // R4

  AST_CRS_HALF: assert property (@(posedge clk) disable iff (rst)
    (!full_duplex && (tx_active || rx_active)) |=> crs); // R6

  AST_CRS_FULL: assert property (@(posedge clk) disable iff (rst)
    full_duplex |=> (crs == $past(rx_active))); // R7

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (!crs && !col)); // R8

  AST_TX_CANCEL: assert property (@(posedge clk) disable iff (rst)
    tx_active |=> !sqe_on); // R9

endmodule

bind mii_crs_col_gen mii_crs_col_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_active   (tx_active),
  .rx_active   (rx_active),
  .full_duplex (full_duplex),
  .speed_100   (speed_100),
  .crs         (crs),
  .col         (col),
  .sqe_on      (sqe_on)
);

// File: tb/mii_crs_col_gen_bench.sv
module mii_crs_col_gen_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx = 1'b0, rx = 1'b0, fd = 1'b0, sp = 1'b0, en = 1'b0, tick = 1'b0;
  logic crs, col;

  int n_chk = 0;
  int n_bad = 0;
  int phase = 0;

  // reference state
  int  m_qc = 0, m_st = 0, m_sc = 0;
  bit  m_lead = 0, m_txp = 0, m_cancel = 0;
  bit  e_crs = 0, e_col = 0, e_act = 0;

  always #2.5 clk = ~clk;

  mii_crs_col_gen u_mii_crs_col_gen (
    .clk(clk), .rst(rst), .tx_active(tx), .rx_active(rx),
    .full_duplex(fd), .speed_100(sp), .sqe_en(en), .bit_tick(tick),
    .crs(crs), .col(col)
  );

  task automatic check(input string tag, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t fd=%0b sp=%0b en=%0b tx=%0b rx=%0b actual=%0b expected=%0b",
               tag, $time, fd, sp, en, tx, rx, act, exp);
    end
  endtask

  task automatic model_update();
    bit coll;
    coll = !fd && tx && rx;
    if (!coll) m_qc = 0;
    else if (tick && m_qc < 7) m_qc++;
    e_act = coll && (sp || m_lead || m_qc == 7);
    m_lead = rx && (m_lead || !tx);
    m_cancel = 0;
    if (fd) m_st = 0;
    else if (tx) begin
      if (m_st != 0) m_cancel = 1;
      m_st = 0;
    end else if (m_txp && en && !sp) begin
      m_st = 1; m_sc = 0;
    end else if (tick && m_st == 1) begin
      if (m_sc == 9) begin m_st = 2; m_sc = 0; end else m_sc++;
    end else if (tick && m_st == 2) begin
      if (m_sc == 9) m_st = 0; else m_sc++;
    end
    m_txp = tx;
    e_col = e_act || (m_st == 2);
    e_crs = rx || (!fd && tx);
  endtask

  task automatic step(input bit t, input bit r);
    string ctag;
    @(negedge clk);
    tx = t; rx = r;
    tick = (phase % 4 == 3);
    phase++;
    @(posedge clk);
    model_update();
    #1;
    check(fd ? "R7 crs" : "R6 crs", crs, e_crs);
    if (fd)            ctag = "R1 col";
    else if (m_cancel) ctag = "R9 col";
    else if (m_st != 0) ctag = "R5 col";
    else if (!(tx && rx)) ctag = "R4 col";
    else if (sp || m_lead) ctag = "R3 col";
    else ctag = "R2 col";
    check(ctag, col, e_col);
  endtask

  task automatic hold(input bit t, input bit r, input int n);
    for (int i = 0; i < n; i++) step(t, r);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tx = 0; rx = 0; tick = 0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_qc = 0; m_st = 0; m_sc = 0; m_lead = 0; m_txp = 0;
    check("R8 crs", crs, 1'b0);
    check("R8 col", col, 1'b0);
  endtask

  initial begin
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int ord = 0; ord < 3; ord++) begin
        for (int ln = 0; ln < 2; ln++) begin
          int olen;
          olen = (ln == 0) ? 20 : 60;
          fd = cfg[0]; sp = cfg[1]; en = cfg[2];
          do_reset();
          hold(0, 0, 8);
          case (ord)
            0: begin hold(0, 1, 6); hold(1, 1, olen); hold(0, 1, 4); end
            1: begin hold(1, 0, 6); hold(1, 1, olen); hold(1, 0, 4); end
            default: begin hold(1, 1, olen); end
          endcase
          hold(0, 0, 30);   // inside heartbeat gap
          hold(1, 0, 8);    // restart cancels it (R9)
          hold(0, 0, 110);  // full gap and pulse (R5)
          hold(0, 1, 12);   // receive only (R7)
          hold(0, 0, 4);
        end
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule